// File: doc/BRIEF.md
# Configuration Host Sequencer

This block is the host side of a target device's configuration handshake. On a start request it pulls an active-low configuration request line low and holds it there until the target reports, on its active-low status line, that it has finished clearing itself. The host then releases the request and waits for status to rise again. After that it streams bitstream words from a local word source to the target over a valid/ready interface. Once the last word has been accepted, it waits for the target's configuration-done and then its init-done indication, with no timeout on either, and then enters user mode. The same start input begins a reconfiguration from user mode.

A blind mode is available for hosts that do not watch the status line. In that mode the request pulse has a fixed length, taken from a clock-frequency parameter and a pulse length in milliseconds (1000 ms by default). Status is ignored, and streaming begins as soon as the request is released. Whenever the target holds ready low, a small counter limits how long valid can stay high, so the host always drops valid within six cycles. An output keeps downstream application logic in reset until init-done has been seen.

Top module: `cfg_host_seq`

## Requirements
- R1: After reset, the request line `cfg_req_n_o` is high, `tgt_valid_o` is low, `err_o` is low, `user_mode_o` is low and `app_rst_o` is high.
- R2: A `start_i` pulse in idle or user mode drives `cfg_req_n_o` low on the next cycle. With blind mode off, the line stays low while `tgt_status_n_i` is high. It returns high one cycle after status is sampled low.
- R3: With blind mode off, after the request is released no word is offered (`tgt_valid_o` low) until `tgt_status_n_i` has been sampled high.
- R4: While streaming, once `tgt_ready_i` has been low for more than min(`stall_lim_i`,5) consecutive sampled cycles, `tgt_valid_o` is low. A limit of L gives exactly L+1 valid-high cycles in a ready-low run when data is available, and never more than six.
- R5: A word counts as moved, and is popped from the source, only on a cycle with `tgt_valid_o` and `tgt_ready_i` both high. `xfer_cnt_o` counts these words from zero for each run, and words reach `tgt_data_o` in source order.
- R6: After the word flagged by `src_last_i` is accepted, the host waits with no time limit for `tgt_conf_done_i`, then for `tgt_init_done_i`. Only then does it raise `user_mode_o`.
- R7: With blind mode off, if status falls while streaming or while waiting for configuration-done, `err_o` rises, the block returns to idle with `cfg_req_n_o` high and `tgt_valid_o` low, and `err_o` stays set until the next start.
- R8: `app_rst_o` stays high from reset or start until init-done has been seen, and falls together with the entry into user mode.
- R9: With `blind_mode_i` high at start, the request is held low for at least the configured pulse length, whatever status does. Streaming then begins without a status wait, and status never raises an error.
- R10: A start in user mode begins a reconfiguration: `user_mode_o` falls, `app_rst_o` rises, and the full sequence runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin configuration or reconfiguration |
| blind_mode_i | input | 1 | Use timed pulse, ignore status (captured at start) |
| stall_lim_i | input | 3 | Ready-low cycles tolerated before valid drops (clamped to 5) |
| src_data_i | input | DATA_W | Bitstream word from local source |
| src_valid_i | input | 1 | Source has a word |
| src_last_i | input | 1 | Current source word is the final one |
| src_ready_o | output | 1 | Pop strobe to source (word accepted by target) |
| cfg_req_n_o | output | 1 | Active-low configuration request to target |
| tgt_status_n_i | input | 1 | Active-low status from target |
| tgt_data_o | output | DATA_W | Word to target |
| tgt_valid_o | output | 1 | Word valid to target |
| tgt_ready_i | input | 1 | Target can accept a word |
| tgt_conf_done_i | input | 1 | Target received full bitstream |
| tgt_init_done_i | input | 1 | Target in user mode |
| user_mode_o | output | 1 | Sequence complete |
| app_rst_o | output | 1 | Hold downstream application logic in reset |
| err_o | output | 1 | Status fell during transfer or configuration-done wait |
| xfer_cnt_o | output | CNT_W | Words accepted in current run |

## Verification
The embedded properties watch every cycle for the rules that hold locally: the request stays low while status is still high in monitored mode, valid is never high after six ready-low cycles, the word count advances only after a real handshake, an error flag rises only after status was low, and the application reset falls only after init-done. Only the directed scenarios can show end-to-end order and content. These include the words arriving intact and in order, the exact number of valid cycles for a given stall limit, the unbounded waits for configuration-done and init-done, the length of the blind pulse with status held low, and a complete reconfiguration out of user mode.

// File: rtl/cfg_host_pkg.sv
package cfg_host_pkg;

    typedef enum logic [3:0] {
        ST_IDLE       = 4'd0,
        ST_REQ_LOW    = 4'd1,
        ST_WAIT_SLOW  = 4'd2,
        ST_REQ_HIGH   = 4'd3,
        ST_WAIT_SHIGH = 4'd4,
        ST_STREAM     = 4'd5,
        ST_WAIT_CDONE = 4'd6,
        ST_WAIT_IDONE = 4'd7,
        ST_USER       = 4'd8
    } seq_state_t;

    localparam logic [2:0] MAX_STALL = 3'd5;

    function automatic logic [2:0] clamp_stall(input logic [2:0] lim);
        return (lim > MAX_STALL) ? MAX_STALL : lim;
    endfunction

endpackage

// File: rtl/cfg_pulse_timer.sv
module cfg_pulse_timer #(
    parameter int unsigned CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int unsigned W = (CYCLES > 1) ? $clog2(CYCLES + 1) : 1;
    localparam logic [W-1:0] LAST = W'(CYCLES - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i)
            cnt_d = '0;
        else if (cnt_q != LAST)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = run_i && (cnt_q == LAST);

    // R9: done only after the timer has actually been running
    a_r9_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && (CYCLES > 1) |-> $past(run_i));

endmodule

// File: rtl/cfg_stream_gate.sv
module cfg_stream_gate
    import cfg_host_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic [2:0] stall_lim_i,
    input  logic       src_valid_i,
    input  logic       tgt_ready_i,
    output logic       tgt_valid_o,
    output logic       fire_o
);
    logic [2:0] low_d, low_q;
    logic [2:0] lim;

    assign lim = clamp_stall(stall_lim_i);

    always_comb begin
        low_d = low_q;
        if (!en_i || tgt_ready_i)
            low_d = '0;
        else if (low_q != 3'd7)
            low_d = low_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) low_q <= '0;
        else        low_q <= low_d;
    end

    assign tgt_valid_o = en_i && src_valid_i && (low_q <= lim);
    assign fire_o      = tgt_valid_o && tgt_ready_i;

    // R4: six consecutive ready-low cycles force valid low
    a_r4_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_ready_i && $past(!tgt_ready_i, 1) && $past(!tgt_ready_i, 2) &&
        $past(!tgt_ready_i, 3) && $past(!tgt_ready_i, 4) &&
        $past(!tgt_ready_i, 5) && $past(!tgt_ready_i, 6) |-> !tgt_valid_o);

endmodule

// File: rtl/cfg_host_seq.sv
module cfg_host_seq
    import cfg_host_pkg::*;
#(
    parameter int unsigned DATA_W        = 32,
    parameter int unsigned CNT_W         = 16,
    parameter int unsigned CLK_HZ        = 125_000_000,
    parameter int unsigned PULSE_MS      = 1000,
    parameter int unsigned PULSE_CYC_OVR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              blind_mode_i,
    input  logic [2:0]        stall_lim_i,
    input  logic [DATA_W-1:0] src_data_i,
    input  logic              src_valid_i,
    input  logic              src_last_i,
    output logic              src_ready_o,
    output logic              cfg_req_n_o,
    input  logic              tgt_status_n_i,
    output logic [DATA_W-1:0] tgt_data_o,
    output logic              tgt_valid_o,
    input  logic              tgt_ready_i,
    input  logic              tgt_conf_done_i,
    input  logic              tgt_init_done_i,
    output logic              user_mode_o,
    output logic              app_rst_o,
    output logic              err_o,
    output logic [CNT_W-1:0]  xfer_cnt_o
);
    localparam int unsigned PULSE_CYC =
        (PULSE_CYC_OVR != 0) ? PULSE_CYC_OVR : (CLK_HZ / 1000) * PULSE_MS;

    typedef struct packed {
        seq_state_t       st;
        logic             blind;
        logic             err;
        logic             app_rst;
        logic [CNT_W-1:0] xfer;
    } seq_regs_t;

    seq_regs_t cur_q, nxt_d;
    logic      fire;
    logic      streaming;
    logic      timer_done;

    assign streaming = (cur_q.st == ST_STREAM);

    cfg_pulse_timer #(.CYCLES(PULSE_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (cur_q.st == ST_WAIT_SLOW && cur_q.blind),
        .done_o (timer_done)
    );

    cfg_stream_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (streaming),
        .stall_lim_i (stall_lim_i),
        .src_valid_i (src_valid_i),
        .tgt_ready_i (tgt_ready_i),
        .tgt_valid_o (tgt_valid_o),
        .fire_o      (fire)
    );

    always_comb begin
        nxt_d = cur_q;
        if (fire)
            nxt_d.xfer = cur_q.xfer + 1'b1;
        unique case (cur_q.st)
            ST_IDLE, ST_USER: begin
                if (start_i) begin
                    nxt_d.st      = ST_REQ_LOW;
                    nxt_d.blind   = blind_mode_i;
                    nxt_d.err     = 1'b0;
                    nxt_d.app_rst = 1'b1;
                    nxt_d.xfer    = '0;
                end
            end
            ST_REQ_LOW:
                nxt_d.st = ST_WAIT_SLOW;
            ST_WAIT_SLOW: begin
                if (cur_q.blind ? timer_done : !tgt_status_n_i)
                    nxt_d.st = ST_REQ_HIGH;
            end
            ST_REQ_HIGH:
                nxt_d.st = cur_q.blind ? ST_STREAM : ST_WAIT_SHIGH;
            ST_WAIT_SHIGH: begin
                if (tgt_status_n_i)
                    nxt_d.st = ST_STREAM;
            end
            ST_STREAM: begin
                if (!cur_q.blind && !tgt_status_n_i) begin
                    nxt_d.st  = ST_IDLE;
                    nxt_d.err = 1'b1;
                end else if (fire && src_last_i) begin
                    nxt_d.st = ST_WAIT_CDONE;
                end
            end
            ST_WAIT_CDONE: begin
                if (!cur_q.blind && !tgt_status_n_i) begin
                    nxt_d.st  = ST_IDLE;
                    nxt_d.err = 1'b1;
                end else if (tgt_conf_done_i) begin
                    nxt_d.st = ST_WAIT_IDONE;
                end
            end
            ST_WAIT_IDONE: begin
                if (tgt_init_done_i) begin
                    nxt_d.st      = ST_USER;
                    nxt_d.app_rst = 1'b0;
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st      <= ST_IDLE;
            cur_q.blind   <= 1'b0;
            cur_q.err     <= 1'b0;
            cur_q.app_rst <= 1'b1;
            cur_q.xfer    <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cfg_req_n_o = !(cur_q.st == ST_REQ_LOW || cur_q.st == ST_WAIT_SLOW);
    assign src_ready_o = fire;
    assign tgt_data_o  = src_data_i;
    assign user_mode_o = (cur_q.st == ST_USER);
    assign app_rst_o   = cur_q.app_rst;
    assign err_o       = cur_q.err;
    assign xfer_cnt_o  = cur_q.xfer;

    // R2: in monitored mode the request is not released while status is still high
    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_q.blind && !cfg_req_n_o && tgt_status_n_i |=> !cfg_req_n_o);

    // R5: the word count advances only after a real handshake
    a_r5_count_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_cnt_o == $past(xfer_cnt_o) + 1'b1 |-> $past(tgt_valid_o && tgt_ready_i));

    // R7: an error only follows a low status sample
    a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $past(!tgt_status_n_i));

    // R8: application reset is released only after init-done
    a_r8_rst_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(app_rst_o) |-> $past(tgt_init_done_i));

    // R8: user mode never coexists with application reset
    a_r8_user_no_rst: assert property (@(posedge clk) disable iff (!rst_n)
        user_mode_o |-> !app_rst_o);

endmodule

// File: tb/cfg_host_seq_tb_top.sv
module cfg_host_seq_tb_top;
    localparam int DW    = 32;
    localparam int CW    = 16;
    localparam int PULSE = 20;
    localparam int NW    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          blind_mode_i = 1'b0;
    logic [2:0]    stall_lim_i = 3'd2;
    logic [DW-1:0] src_data_i;
    logic          src_valid_i;
    logic          src_last_i;
    logic          src_ready_o;
    logic          cfg_req_n_o;
    logic          tgt_status_n_i = 1'b1;
    logic [DW-1:0] tgt_data_o;
    logic          tgt_valid_o;
    logic          tgt_ready_i = 1'b1;
    logic          tgt_conf_done_i = 1'b0;
    logic          tgt_init_done_i = 1'b0;
    logic          user_mode_o;
    logic          app_rst_o;
    logic          err_o;
    logic [CW-1:0] xfer_cnt_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [DW-1:0] words [NW];
    int src_idx = 0;
    int rx_idx = 0;
    int rx_bad = 0;
    bit src_load = 1'b0;

    always #4 clk = ~clk;

    cfg_host_seq #(.DATA_W(DW), .CNT_W(CW), .PULSE_CYC_OVR(PULSE)) dut_i (.*);

    assign src_valid_i = (src_idx < NW);
    assign src_data_i  = (src_idx < NW) ? words[src_idx] : '0;
    assign src_last_i  = (src_idx == NW - 1);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (src_load) begin
            src_idx <= 0;
            rx_idx  <= 0;
            rx_bad  <= 0;
        end else if (tgt_valid_o && tgt_ready_i) begin
            src_idx <= src_idx + 1;
            rx_idx  <= rx_idx + 1;
            if (tgt_data_o !== words[rx_idx]) rx_bad <= rx_bad + 1;
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [31:0] base);
        for (int i = 0; i < NW; i++) words[i] = base + 32'(i) * 32'h0101_0001;
        src_load = 1'b1;
        tick();
        src_load = 1'b0;
    endtask

    task automatic pulse_start(input logic blind);
        blind_mode_i = blind;
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
    endtask

    // monitored handshake up to streaming
    task automatic handshake();
        pulse_start(1'b0);
        chk("R2 req low after start", cfg_req_n_o, 1'b0);
        tick(6);
        chk("R2 req held while status high", cfg_req_n_o, 1'b0);
        tgt_status_n_i = 1'b0;
        tick();
        chk("R2 req released after status low", cfg_req_n_o, 1'b1);
        tick(4);
        chk("R3 no valid before status high", tgt_valid_o, 1'b0);
        tgt_status_n_i = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        chk("R1 req", cfg_req_n_o, 1'b1);
        chk("R1 valid", tgt_valid_o, 1'b0);
        chk("R1 err", err_o, 1'b0);
        chk("R1 user", user_mode_o, 1'b0);
        chk("R1 app_rst", app_rst_o, 1'b1);
    endtask

    task automatic stall_run(input logic [2:0] lim, input int exp_valid);
        int nv = 0;
        logic [CW-1:0] cnt0;
        stall_lim_i = lim;
        tgt_ready_i = 1'b0;
        cnt0 = xfer_cnt_o;
        for (int i = 0; i < 10; i++) begin
            if (tgt_valid_o) nv++;
            tick();
        end
        chk("R4 valid cycles in stall", 32'(nv), 32'(exp_valid));
        chk("R5 count frozen while not ready", 32'(xfer_cnt_o), 32'(cnt0));
        tgt_ready_i = 1'b1;
    endtask

    task automatic finish_run(input string tag);
        int g = 0;
        while (src_idx < NW && g < 200) begin tick(); g++; end
        tick();
        chk({tag, " R5 word count"}, 32'(xfer_cnt_o), 32'(NW));
        chk({tag, " R5 data order"}, 32'(rx_bad), 32'd0);
        tick(30);
        chk({tag, " R6 waits for conf_done"}, user_mode_o, 1'b0);
        tgt_conf_done_i = 1'b1;
        tick(40);
        chk({tag, " R6 waits for init_done"}, user_mode_o, 1'b0);
        chk({tag, " R8 app_rst held"}, app_rst_o, 1'b1);
        tgt_init_done_i = 1'b1;
        tick();
        chk({tag, " R6 user mode"}, user_mode_o, 1'b1);
        chk({tag, " R8 app_rst released"}, app_rst_o, 1'b0);
    endtask

    task automatic t_config();
        load(32'h1000_0000);
        handshake();
        tick(3);
        stall_run(3'd2, 3);
        tick(2);
        stall_run(3'd7, 6);
        finish_run("cfg");
    endtask

    task automatic t_reconfig();
        load(32'hA000_0000);
        pulse_start(1'b0);
        chk("R10 user mode dropped", user_mode_o, 1'b0);
        chk("R10 app_rst reasserted", app_rst_o, 1'b1);
        chk("R10 count cleared", 32'(xfer_cnt_o), 32'd0);
        tgt_conf_done_i = 1'b0;
        tgt_init_done_i = 1'b0;
        tick(2);
        tgt_status_n_i = 1'b0;
        tick();
        chk("R10 req released", cfg_req_n_o, 1'b1);
        tgt_status_n_i = 1'b1;
        tick(2);
        stall_run(3'd0, 1);
        finish_run("reconfig");
    endtask

    task automatic t_error();
        load(32'h5500_0000);
        tgt_conf_done_i = 1'b0;
        tgt_init_done_i = 1'b0;
        handshake();
        tick(3);
        tgt_status_n_i = 1'b0;
        tick();
        chk("R7 err raised", err_o, 1'b1);
        chk("R7 req high", cfg_req_n_o, 1'b1);
        chk("R7 valid low", tgt_valid_o, 1'b0);
        tick(3);
        chk("R7 err sticky", err_o, 1'b1);
        chk("R7 app_rst still high", app_rst_o, 1'b1);
    endtask

    task automatic t_blind();
        int low = 0;
        int g = 0;
        load(32'hB000_0000);
        tgt_status_n_i = 1'b0;
        pulse_start(1'b1);
        chk("R9 err cleared on start", err_o, 1'b0);
        while (!cfg_req_n_o && g < 1000) begin low++; tick(); g++; end
        checks++;
        if (low < PULSE || low > PULSE + 1) begin
            errors++;
            $display("FAIL R9 pulse length: actual %0d expected %0d..%0d", low, PULSE, PULSE + 1);
        end
        tick();
        chk("R9 streaming without status", tgt_valid_o, 1'b1);
        tick(4);
        chk("R9 no error from status", err_o, 1'b0);
        finish_run("blind");
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_config();
        t_reconfig();
        t_error();
        t_blind();
        done = 1'b1;
    end

    initial begin
        wait (done || cyc > 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule